// File: doc/BRIEF.md
# CRC-64 Sector Signature Engine with Automatic Reference Compare

This block compresses a stream of 64-bit data words into a 64-bit signature and, in automatic mode, checks every finished sector against a reference value that was written ahead of it. A DMA channel or a bus master delivers data words through one write strobe and reference values through a second strobe. Each port carries a 64-bit value in big-endian placement. The upper half of the logical value sits in bits [31:0] of the port and the lower half sits in bits [63:32]. The block exchanges the two halves before it uses the value.

Software chooses how many words make a sector and how many sectors make a block. It starts a fresh run with a channel reset and then watches a busy flag, four sticky status flags and one interrupt line. With the compare disabled, the block only produces signatures. The signature of each finished sector can be read from a holding output.

Top module: `crc_sig_checker`

## Requirements
- R1: Each data word, after its halves are exchanged, is folded into the running signature in one cycle. The fold processes the word bit by bit, from bit 63 down to bit 0. In each bit step the feedback is the signature's bit 63 XOR the data bit. The shifted signature takes the feedback in bit 0, and bits 1, 3 and 4 also take the previous bit below XOR the feedback.
- R2: The write that completes a sector loads the fold result into `sector_sig` and reseeds the running signature `sig_value` to zero. A sector is completed by the pattern-count-th word of that sector.
- R3: Values on `pat_cnt_cfg` and `sec_cnt_cfg` are captured only during `rst` or `chan_rst`. Any change at other times has no effect on sector or block lengths. Both counts must be nonzero.
- R4: `chan_rst` clears the running signature, the word and sector counters, `busy` and any pending reference. A data write in the same cycle is ignored.
- R5: `busy` rises after the first data word of a block. It stays high until the write that completes the last sector of the block and is low in the cycle after that write.
- R6: When `auto_en` is 1 and a sector completes with a reference pending, the block consumes the reference. If the half-exchanged reference differs from the sector signature, it sets status bit 1 (fail). A match sets nothing.
- R7: Status bit 2 (overrun) is set when a reference is written while an earlier one is still pending and no sector check consumes it in that cycle. The newer reference replaces the older one.
- R8: When `auto_en` is 1 and a sector completes with no reference pending, status bit 3 (underrun) is set and no compare is made, so bit 1 stays unchanged.
- R9: Status bit 0 (complete) is set by the write that completes the last sector of a block.
- R10: Writing 1 to a bit of `flag_clr` clears that status bit. A set event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some status bit is 1 and its matching `irq_en` bit was 1 at the edge that last updated the flags.
- R12: When `auto_en` is 0, sector completion makes no compare, consumes no reference and sets neither fail nor underrun.
- R13: After `rst`, `busy`, `status`, `irq`, `sig_value` and `sector_sig` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_rst | input | 1 | Channel restart; captures counts and clears progress |
| auto_en | input | 1 | 1 enables automatic sector compare |
| pat_cnt_cfg | input | PAT_W | Words per sector, captured on reset |
| sec_cnt_cfg | input | SEC_W | Sectors per block, captured on reset |
| sig_wr_vld | input | 1 | Data word write strobe |
| sig_wr_data | input | 64 | Data word, big-endian halves |
| ref_wr_vld | input | 1 | Reference write strobe |
| ref_wr_data | input | 64 | Reference value, big-endian halves |
| irq_en | input | 4 | Interrupt enable per status bit |
| flag_clr | input | 4 | Write-one-to-clear per status bit |
| busy | output | 1 | Block in progress |
| status | output | 4 | Bit 0 complete, 1 fail, 2 overrun, 3 underrun |
| irq | output | 1 | Interrupt request |
| sig_value | output | 64 | Running signature |
| sector_sig | output | 64 | Signature of the last finished sector |

## Verification
The assertions take for granted that the captured pattern and sector counts are nonzero, because a zero count would leave the word counter with no terminal value. They also assume that every strobe is a clean single-cycle level sampled at the rising edge. The stimulus programs only counts of one or more. It changes all inputs on the falling edge, so each write occupies exactly one rising edge. It raises `chan_rst` before each new count setting is meant to apply.

// File: rtl/crc_sig_pkg.sv
package crc_sig_pkg;
  localparam int SIG_W  = 64;
  localparam int HALF_W = SIG_W / 2;
  localparam int NFLAG  = 4;
  localparam int ST_DONE = 0;
  localparam int ST_FAIL = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_UND  = 3;

  // exchange the two 32-bit halves of a big-endian placed value
  function automatic logic [SIG_W-1:0] half_swap(input logic [SIG_W-1:0] v);
    return {v[HALF_W-1:0], v[SIG_W-1:HALF_W]};
  endfunction

  // one whole word folded MSB first, taps at 0,1,3,4
  function automatic logic [SIG_W-1:0] fold_word(input logic [SIG_W-1:0] seed,
                                                 input logic [SIG_W-1:0] word);
    logic [SIG_W-1:0] acc;
    logic             fb;
    acc = seed;
    for (int b = SIG_W - 1; b >= 0; b--) begin
      fb  = acc[SIG_W-1] ^ word[b];
      acc = {acc[SIG_W-2:0], fb};
      acc[1] = acc[1] ^ fb;
      acc[3] = acc[3] ^ fb;
      acc[4] = acc[4] ^ fb;
    end
    return acc;
  endfunction
endpackage

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl #(
  parameter int PAT_W = 16,
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_rst,
  input  logic             word_vld,
  input  logic [PAT_W-1:0] pat_cfg,
  input  logic [SEC_W-1:0] sec_cfg,
  output logic             busy,
  output logic             sector_end,
  output logic             block_end
);
  logic [PAT_W-1:0] pat_lim, pat_idx;
  logic [SEC_W-1:0] sec_lim, sec_idx;
  logic             busy_q;
  logic             take;

  assign take       = word_vld && !chan_rst;
  assign sector_end = take && (pat_idx == pat_lim - PAT_W'(1));
  assign block_end  = sector_end && (sec_idx == sec_lim - SEC_W'(1));
  assign busy       = busy_q;

  always_ff @(posedge clk) begin
    if (rst || chan_rst) begin
      pat_lim <= pat_cfg;
      sec_lim <= sec_cfg;
      pat_idx <= '0;
      sec_idx <= '0;
      busy_q  <= 1'b0;
    end else if (take) begin
      busy_q <= !block_end;
      if (sector_end) begin
        pat_idx <= '0;
        sec_idx <= block_end ? '0 : sec_idx + SEC_W'(1);
      end else begin
        pat_idx <= pat_idx + PAT_W'(1);
      end
    end
  end

  a_r5_busy_drops: assert property (@(posedge clk) disable iff (rst)
    block_end |=> !busy);
  a_r5_busy_rises: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !chan_rst && !block_end) |=> busy);
  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    (pat_lim != '0) |-> (pat_idx < pat_lim));
  a_r4_chan_clear: assert property (@(posedge clk) disable iff (rst)
    chan_rst |=> (pat_idx == '0 && sec_idx == '0 && !busy));
endmodule

// File: rtl/crc_fold_unit.sv
module crc_fold_unit
  import crc_sig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_rst,
  input  logic             word_vld,
  input  logic [SIG_W-1:0] word,
  input  logic             sector_end,
  output logic [SIG_W-1:0] fold_next,
  output logic [SIG_W-1:0] sig_q,
  output logic [SIG_W-1:0] sector_q
);
  assign fold_next = fold_word(sig_q, word);

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q    <= '0;
      sector_q <= '0;
    end else if (chan_rst) begin
      sig_q <= '0;
    end else if (word_vld) begin
      if (sector_end) begin
        sector_q <= fold_next;
        sig_q    <= '0;
      end else begin
        sig_q <= fold_next;
      end
    end
  end

  a_r2_reseed: assert property (@(posedge clk) disable iff (rst)
    (sector_end && !chan_rst) |=> (sig_q == '0));
  a_r2_holding: assert property (@(posedge clk) disable iff (rst)
    (!sector_end || chan_rst) |=> $stable(sector_q));
endmodule

// File: rtl/crc_cmp_unit.sv
module crc_cmp_unit
  import crc_sig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_rst,
  input  logic             auto_en,
  input  logic             ref_vld,
  input  logic [SIG_W-1:0] ref_word,
  input  logic             sector_end,
  input  logic             block_end,
  input  logic [SIG_W-1:0] sector_value,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] irq_en,
  output logic [NFLAG-1:0] status,
  output logic             irq
);
  logic [SIG_W-1:0] ref_q;
  logic             pend_q;
  logic             consume;
  logic [NFLAG-1:0] set_v, stat_d;

  assign consume = sector_end && auto_en && pend_q;

  always_comb begin
    set_v          = '0;
    set_v[ST_DONE] = block_end;
    set_v[ST_FAIL] = consume && (ref_q != sector_value);
    set_v[ST_OVR]  = ref_vld && !chan_rst && pend_q && !consume;
    set_v[ST_UND]  = sector_end && auto_en && !pend_q;
    stat_d         = (status & ~flag_clr) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      pend_q <= 1'b0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= stat_d;
      irq    <= |(stat_d & irq_en);
      if (chan_rst) begin
        pend_q <= 1'b0;
      end else if (ref_vld) begin
        ref_q  <= ref_word;
        pend_q <= 1'b1;
      end else if (consume) begin
        pend_q <= 1'b0;
      end
    end
  end

  a_r8_underrun: assert property (@(posedge clk) disable iff (rst)
    (sector_end && auto_en && !pend_q) |=> (status[ST_UND] && $stable(status[ST_FAIL])));
  a_r7_overrun: assert property (@(posedge clk) disable iff (rst)
    (ref_vld && !chan_rst && pend_q && !(sector_end && auto_en)) |=> status[ST_OVR]);
  a_r11_irq_map: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & $past(irq_en)));
  a_r12_no_compare: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && !status[ST_FAIL] && !status[ST_UND]) |=> (!status[ST_FAIL] && !status[ST_UND]));
endmodule

// File: rtl/crc_sig_checker.sv
module crc_sig_checker
  import crc_sig_pkg::*;
#(
  parameter int PAT_W = 16,
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_rst,
  input  logic             auto_en,
  input  logic [PAT_W-1:0] pat_cnt_cfg,
  input  logic [SEC_W-1:0] sec_cnt_cfg,
  input  logic             sig_wr_vld,
  input  logic [63:0]      sig_wr_data,
  input  logic             ref_wr_vld,
  input  logic [63:0]      ref_wr_data,
  input  logic [3:0]       irq_en,
  input  logic [3:0]       flag_clr,
  output logic             busy,
  output logic [3:0]       status,
  output logic             irq,
  output logic [63:0]      sig_value,
  output logic [63:0]      sector_sig
);
  logic             sector_end, block_end;
  logic [SIG_W-1:0] word_sw, ref_sw, fold_next;

  assign word_sw = half_swap(sig_wr_data);
  assign ref_sw  = half_swap(ref_wr_data);

  crc_seq_ctrl #(.PAT_W(PAT_W), .SEC_W(SEC_W)) u_seq (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .word_vld(sig_wr_vld),
    .pat_cfg(pat_cnt_cfg), .sec_cfg(sec_cnt_cfg),
    .busy(busy), .sector_end(sector_end), .block_end(block_end)
  );

  crc_fold_unit u_fold (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .word_vld(sig_wr_vld),
    .word(word_sw), .sector_end(sector_end),
    .fold_next(fold_next), .sig_q(sig_value), .sector_q(sector_sig)
  );

  crc_cmp_unit u_cmp (
    .clk(clk), .rst(rst), .chan_rst(chan_rst), .auto_en(auto_en),
    .ref_vld(ref_wr_vld), .ref_word(ref_sw),
    .sector_end(sector_end), .block_end(block_end), .sector_value(fold_next),
    .flag_clr(flag_clr), .irq_en(irq_en), .status(status), .irq(irq)
  );

  a_r13_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!busy && status == '0 && !irq));
endmodule

// File: tb/tb_crc_sig_checker.sv
module tb_crc_sig_checker;
  logic        clk = 1'b0;
  logic        rst, chan_rst, auto_en;
  logic [15:0] pat_cnt_cfg;
  logic [7:0]  sec_cnt_cfg;
  logic        sig_wr_vld, ref_wr_vld;
  logic [63:0] sig_wr_data, ref_wr_data;
  logic [3:0]  irq_en, flag_clr;
  logic        busy, irq;
  logic [3:0]  status;
  logic [63:0] sig_value, sector_sig;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  crc_sig_checker dut (.*);

  localparam logic [63:0] VEC [6] = '{
    64'h8DF8A32C74B91F3E, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF,
    64'h8000000000000001, 64'h0123456789ABCDEF, 64'hA5A55A5A00FF00FF
  };

  function automatic logic [63:0] bfold(input logic [63:0] c, input logic [63:0] d);
    logic [63:0] n;
    logic fb;
    for (int i = 63; i >= 0; i--) begin
      fb = c[63] ^ d[i];
      n = c << 1;
      n[0] = fb;
      n[1] = c[0] ^ fb;
      n[3] = c[2] ^ fb;
      n[4] = c[3] ^ fb;
      c = n;
    end
    return c;
  endfunction

  function automatic logic [63:0] place(input logic [63:0] v);
    return {v[31:0], v[63:32]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_data(input logic [63:0] logical);
    @(negedge clk);
    sig_wr_vld = 1'b1; sig_wr_data = place(logical);
    @(negedge clk);
    sig_wr_vld = 1'b0;
  endtask

  task automatic wr_ref(input logic [63:0] logical);
    @(negedge clk);
    ref_wr_vld = 1'b1; ref_wr_data = place(logical);
    @(negedge clk);
    ref_wr_vld = 1'b0;
  endtask

  task automatic restart(input logic [15:0] p, input logic [7:0] s);
    @(negedge clk);
    pat_cnt_cfg = p; sec_cnt_cfg = s; chan_rst = 1'b1; flag_clr = 4'hF;
    @(negedge clk);
    chan_rst = 1'b0; flag_clr = 4'h0;
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] acc;
    rst = 1'b1; chan_rst = 0; auto_en = 0; pat_cnt_cfg = 16'd1; sec_cnt_cfg = 8'd1;
    sig_wr_vld = 0; ref_wr_vld = 0; sig_wr_data = '0; ref_wr_data = '0;
    irq_en = 4'h0; flag_clr = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 busy", {63'd0, busy}, 64'd0);
    chk("R13 status", {60'd0, status}, 64'd0);
    chk("R13 irq", {63'd0, irq}, 64'd0);
    chk("R13 sig_value", sig_value, 64'd0);
    chk("R13 sector_sig", sector_sig, 64'd0);

    // R1/R2 vector table, one word per sector
    foreach (VEC[i]) begin
      wr_data(VEC[i]);
      chk("R1 sector signature", sector_sig, bfold(64'd0, VEC[i]));
      chk("R2 reseed", sig_value, 64'd0);
    end
    chk("R12 no underrun in capture mode", {63'd0, status[3]}, 64'd0);
    chk("R9 complete set", {63'd0, status[0]}, 64'd1);

    // R3 change counts without channel reset: still one word per sector
    @(negedge clk); pat_cnt_cfg = 16'd3; sec_cnt_cfg = 8'd2;
    wr_data(VEC[4]);
    chk("R3 old count kept", sector_sig, bfold(64'd0, VEC[4]));

    // R3/R5 take effect after chan_rst: 3 words x 2 sectors
    restart(16'd3, 8'd2);
    wr_data(VEC[0]);
    chk("R5 busy after first word", {63'd0, busy}, 64'd1);
    chk("R3 sector not yet done", sector_sig, bfold(64'd0, VEC[4]));
    chk("R1 running", sig_value, bfold(64'd0, VEC[0]));
    wr_data(VEC[1]);
    wr_data(VEC[2]);
    acc = bfold(bfold(bfold(64'd0, VEC[0]), VEC[1]), VEC[2]);
    chk("R2 three-word sector", sector_sig, acc);
    chk("R5 busy between sectors", {63'd0, busy}, 64'd1);
    chk("R9 complete not yet", {63'd0, status[0]}, 64'd0);
    wr_data(VEC[3]); wr_data(VEC[4]); wr_data(VEC[5]);
    acc = bfold(bfold(bfold(64'd0, VEC[3]), VEC[4]), VEC[5]);
    chk("R2 second sector", sector_sig, acc);
    chk("R5 busy clear at block end", {63'd0, busy}, 64'd0);
    chk("R9 complete at block end", {63'd0, status[0]}, 64'd1);

    // R4 chan_rst mid sector
    wr_data(VEC[0]);
    restart(16'd3, 8'd2);
    chk("R4 sig cleared", sig_value, 64'd0);
    chk("R4 busy cleared", {63'd0, busy}, 64'd0);

    // R6 auto compare, match then mismatch
    @(negedge clk); auto_en = 1'b1;
    restart(16'd1, 8'd1);
    wr_ref(bfold(64'd0, VEC[0]));
    wr_data(VEC[0]);
    chk("R6 match no fail", {63'd0, status[1]}, 64'd0);
    chk("R8 no underrun with ref", {63'd0, status[3]}, 64'd0);
    wr_ref(64'h1234);
    wr_data(VEC[0]);
    chk("R6 mismatch fail", {63'd0, status[1]}, 64'd1);
    chk("R11 masked irq", {63'd0, irq}, 64'd0);
    @(negedge clk); irq_en = 4'b0010;
    @(negedge clk);
    chk("R11 enabled irq", {63'd0, irq}, 64'd1);

    // R10 write-one-to-clear
    @(negedge clk); flag_clr = 4'b0010;
    @(negedge clk); flag_clr = 4'b0000;
    chk("R10 fail cleared", {63'd0, status[1]}, 64'd0);
    chk("R11 irq drops", {63'd0, irq}, 64'd0);

    // R8 underrun, no fail
    wr_data(VEC[2]);
    chk("R8 underrun set", {63'd0, status[3]}, 64'd1);
    chk("R8 no fail", {63'd0, status[1]}, 64'd0);

    // R7 overrun; newer reference replaces older
    wr_ref(64'hDEAD);
    wr_ref(bfold(64'd0, VEC[3]));
    chk("R7 overrun", {63'd0, status[2]}, 64'd1);
    wr_data(VEC[3]);
    chk("R7 newest ref used", {63'd0, status[1]}, 64'd0);

    // R10 set wins over clear
    @(negedge clk); flag_clr = 4'b1000; sig_wr_vld = 1'b1; sig_wr_data = place(VEC[1]);
    @(negedge clk); flag_clr = 4'b0000; sig_wr_vld = 1'b0;
    chk("R10 set beats clear", {63'd0, status[3]}, 64'd1);

    // R12 capture mode consumes no reference
    restart(16'd1, 8'd1);
    @(negedge clk); auto_en = 1'b0;
    wr_ref(64'h55);
    wr_data(VEC[1]);
    chk("R12 no fail", {63'd0, status[1]}, 64'd0);
    @(negedge clk); auto_en = 1'b1;
    wr_data(VEC[1]);
    chk("R12 ref kept pending", {62'd0, status[3], status[1]}, 64'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule